// File: doc/BRIEF.md
# Serial GF(3^m) Polynomial Multiplier

This block multiplies two elements of the ternary extension field GF(3^m), held in polynomial basis, and returns the product reduced modulo the trinomial x^M + x^K − 1. Every ternary coefficient travels on two wires in a redundant code. The multiplier operand is consumed from its most significant coefficient downwards. In each cycle the block applies D multiply-accumulate steps acc ← acc·x mod f + b·A, so one product takes ceil(M/D) cycles. D = 1 gives the fully serial form; D = 4, 8 or 16 gives the digit-serial forms.

Operands are presented with a one-cycle start pulse. `busy_o` acts as the inverse of a ready signal: a start is accepted only on a clock edge where `busy_o` is low, and is dropped otherwise. The output has no back-pressure. The product is valid in the cycle where `done_o` is high, and it stays on `prod_o` until the next start is accepted. A consumer that needs the value later must capture it in that window. The default field is M = 97 with the middle term at K = 16. Smaller M values are legal for testing, with 0 < K < M.

Top module: `gf3m_serial_mul`

## Requirements
- R1: Each coefficient is a 2-bit code {hi, lo}. 00 and 01 both mean zero, 10 means one and 11 means two. An operand coefficient is treated as zero exactly when its hi bit is 0, whatever its lo bit.
- R2: Every coefficient on `prod_o` is normalised, so zero is always driven as 00 and never as 01.
- R3: When `done_o` is high, `prod_o` equals A·B reduced with x^M replaced by 1 − x^K. Coefficient j sits on bits [2j+1:2j].
- R4: If a start is accepted at clock edge n, `busy_o` is high from edge n to edge n+N, with N = ceil(M/D). `done_o` is high in the cycle after edge n+N, and `busy_o` is low in that cycle.
- R5: `done_o` is never high in two consecutive cycles.
- R6: A start raised while `busy_o` is high is ignored. The running product, its timing and the number of completions are unchanged.
- R7: While the block is idle and no start is accepted, `prod_o` does not change.
- R8: After reset, `busy_o` and `done_o` are low and `prod_o` is all zero.
- R9: When M is not a multiple of D, the multiplier operand is padded with leading zeros. The product is still exact and takes ceil(M/D) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while `busy_o` is low |
| a_i | input | 2*M | Multiplicand, coefficient j on bits [2j+1:2j] |
| b_i | input | 2*M | Multiplier, consumed from its top coefficient down |
| busy_o | output | 1 | A product is being computed |
| done_o | output | 1 | One-cycle flag: `prod_o` holds the product |
| prod_o | output | 2*M | Reduced product, normalised code |

## Verification
The assertions check on every cycle that the done flag is a single-cycle pulse and that it arrives exactly N busy cycles after an accepted start. They also check that no redundant zero code ever appears on a completed product, and that the result holds still while the block is idle. Only the bench scenarios can show that the product values are correct, including the wrap of the top coefficient into positions 0 and K. The same holds for treating the 01 zero code as zero on input, for exactness with leading-zero padding in digit mode, and for dropping a start that arrives mid-product.

// File: rtl/gf3_pkg.sv
package gf3_pkg;
  // Ternary coefficient code: 00/01 zero, 10 one, 11 two.
  typedef logic [1:0] trit_t;

  function automatic logic [1:0] trit_val(trit_t t);
    return t[1] ? (t[0] ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  function automatic trit_t trit_enc(logic [1:0] v);
    case (v)
      2'd0:    return 2'b00;
      2'd1:    return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic trit_t trit_add(trit_t a, trit_t b);
    logic [2:0] s;
    s = {1'b0, trit_val(a)} + {1'b0, trit_val(b)};
    if (s >= 3'd3) s = s - 3'd3;
    return trit_enc(s[1:0]);
  endfunction

  function automatic trit_t trit_neg(trit_t a);
    return a[1] ? {1'b1, ~a[0]} : 2'b00;
  endfunction

  function automatic trit_t trit_sub(trit_t a, trit_t b);
    return trit_add(a, trit_neg(b));
  endfunction

  // 1*1=1, 1*2=2, 2*2=1: the low bits combine by XOR when both are nonzero.
  function automatic trit_t trit_mul(trit_t a, trit_t b);
    return (a[1] && b[1]) ? {1'b1, a[0] ^ b[0]} : 2'b00;
  endfunction
endpackage

// File: rtl/gf3m_mac_step.sv
// One most-significant-first step: acc*x mod (x^M + x^K - 1) + b*A.
module gf3m_mac_step
  import gf3_pkg::*;
#(
  parameter int M = 97,
  parameter int K = 16
) (
  input  logic [2*M-1:0] acc_i,
  input  logic [2*M-1:0] a_i,
  input  trit_t          b_i,
  output logic [2*M-1:0] acc_o
);
  trit_t top;
  assign top = acc_i[2*M-1 -: 2];

  always_comb begin
    acc_o = '0;
    for (int j = 0; j < M; j++) begin
      trit_t sh;
      if (j == 0)      sh = top;                                  // x^M -> +1
      else if (j == K) sh = trit_sub(acc_i[2*(j-1) +: 2], top);   // x^M -> -x^K
      else             sh = acc_i[2*(j-1) +: 2];
      acc_o[2*j +: 2] = trit_add(sh, trit_mul(b_i, a_i[2*j +: 2]));
    end
  end
endmodule

// File: rtl/gf3m_digit_stage.sv
// D chained MAC steps; the highest coefficient of the digit goes first.
module gf3m_digit_stage
  import gf3_pkg::*;
#(
  parameter int M = 97,
  parameter int K = 16,
  parameter int D = 1
) (
  input  logic [2*M-1:0] acc_i,
  input  logic [2*M-1:0] a_i,
  input  logic [2*D-1:0] dig_i,
  output logic [2*M-1:0] acc_o
);
  logic [2*M-1:0] chain [D+1];
  assign chain[0] = acc_i;

  for (genvar g = 0; g < D; g++) begin : g_step
    gf3m_mac_step #(.M(M), .K(K)) step_i (
      .acc_i (chain[g]),
      .a_i   (a_i),
      .b_i   (dig_i[2*(D-1-g) +: 2]),
      .acc_o (chain[g+1])
    );
  end

  assign acc_o = chain[D];
endmodule

// File: rtl/gf3m_seq.sv
// Cycle sequencer: accepts a start when idle, counts N steps, pulses done.
module gf3m_seq #(
  parameter int N = 97
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt_q;

  assign load_o = start_i & ~busy_o;
  assign step_o = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_o <= 1'b1;
        cnt_q  <= CW'(N);
      end else if (busy_o) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gf3m_serial_mul.sv
module gf3m_serial_mul
  import gf3_pkg::*;
#(
  parameter int M = 97,
  parameter int K = 16,
  parameter int D = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*M-1:0] a_i,
  input  logic [2*M-1:0] b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*M-1:0] prod_o
);
  localparam int N  = (M + D - 1) / D;  // cycles per product
  localparam int PW = N * D;            // padded multiplier length

  logic load, step;
  logic [2*M-1:0]  a_q, acc_q, acc_nxt;
  logic [2*PW-1:0] b_q, b_ext;

  gf3m_seq #(.N(N)) seq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  gf3m_digit_stage #(.M(M), .K(K), .D(D)) stage_i (
    .acc_i (acc_q),
    .a_i   (a_q),
    .dig_i (b_q[2*PW-1 -: 2*D]),
    .acc_o (acc_nxt)
  );

  always_comb begin
    b_ext = '0;
    b_ext[2*M-1:0] = b_i;  // leading zeros pad the top digit
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else if (load) begin
      a_q   <= a_i;
      b_q   <= b_ext;
      acc_q <= '0;
    end else if (step) begin
      acc_q <= acc_nxt;
      b_q   <= b_q << (2 * D);
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/gf3m_mul_chk.sv
module gf3m_mul_chk #(
  parameter int M = 97,
  parameter int D = 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*M-1:0] prod_o
);
  localparam int N = (M + D - 1) / D;

  logic [31:0] busy_cnt;
  logic        has_redundant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 busy_cnt <= '0;
    else if (start_i && !busy_o) busy_cnt <= '0;
    else if (busy_o)             busy_cnt <= busy_cnt + 32'd1;
  end

  always_comb begin
    has_redundant = 1'b0;
    for (int j = 0; j < M; j++)
      if (prod_o[2*j +: 2] == 2'b01) has_redundant = 1'b1;
  end

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  prod_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !has_redundant);

  // R4
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt == 32'(N)));

  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

bind gf3m_serial_mul gf3m_mul_chk #(.M(M), .D(D)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .prod_o (prod_o)
);

// File: tb/gf3m_serial_mul_tb_top.sv
`timescale 1ns/1ps
module gf3m_serial_mul_tb_top;
  localparam int BM = 13;
  localparam int BK = 4;
  localparam int N1 = BM;             // D = 1
  localparam int N4 = (BM + 3) / 4;   // D = 4, padded
  localparam int W  = 2 * BM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic busy1, done1, busy4, done4;
  logic [W-1:0] prod1, prod4;

  always #10 clk = ~clk;  // 50 MHz

  gf3m_serial_mul #(.M(BM), .K(BK), .D(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_in), .b_i(b_in),
    .busy_o(busy4), .done_o(done4), .prod_o(prod4));

  gf3m_serial_mul #(.M(BM), .K(BK), .D(1)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_in), .b_i(b_in),
    .busy_o(busy1), .done_o(done1), .prod_o(prod1));

  int nvec = 0, nbad = 0;
  int pushes = 0, nd1 = 0, nd4 = 0;
  logic [W-1:0] q1[$], q4[$];
  logic [W-1:0] last_exp = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] enc_rand(input bit alt_zero);
    logic [W-1:0] v;
    for (int j = 0; j < BM; j++) begin
      int r = $urandom % 3;
      v[2*j +: 2] = (r == 0) ? ((alt_zero && $urandom % 2) ? 2'b01 : 2'b00)
                  : (r == 1) ? 2'b10 : 2'b11;
    end
    return v;
  endfunction

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    int pa[BM], pb[BM], pr[2*BM];
    logic [W-1:0] r;
    for (int j = 0; j < BM; j++) begin
      pa[j] = a[2*j+1] ? (a[2*j] ? 2 : 1) : 0;
      pb[j] = b[2*j+1] ? (b[2*j] ? 2 : 1) : 0;
    end
    for (int j = 0; j < 2*BM; j++) pr[j] = 0;
    for (int i = 0; i < BM; i++)
      for (int j = 0; j < BM; j++) pr[i+j] = (pr[i+j] + pa[i]*pb[j]) % 3;
    for (int d = 2*BM-2; d >= BM; d--) begin
      int c = pr[d];
      pr[d] = 0;
      pr[d-BM]    = (pr[d-BM] + c) % 3;
      pr[d-BM+BK] = (pr[d-BM+BK] + 2*c) % 3;
    end
    for (int j = 0; j < BM; j++)
      r[2*j +: 2] = (pr[j] == 0) ? 2'b00 : (pr[j] == 1) ? 2'b10 : 2'b11;
    return r;
  endfunction

  function automatic bit has01(input logic [W-1:0] v);
    for (int j = 0; j < BM; j++) if (v[2*j +: 2] == 2'b01) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy1 || busy4) @(negedge clk);
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] exp);
    wait_idle();
    a_in = a; b_in = b; start = 1'b1;
    q1.push_back(exp); q4.push_back(exp);
    pushes++;
    last_exp = exp;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor, serial instance
  initial begin
    int cyc = 0, t0 = 0;
    logic pb = 1'b0, pd = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (busy1 && !pb) t0 = cyc;
      if (pd && done1) chk(1'b0, "R5 serial double done", 64'(done1), 64'(0));
      if (done1) begin
        logic [W-1:0] e;
        nd1++;
        chk(cyc - t0 == N1, "R4 serial latency", 64'(cyc - t0), 64'(N1));
        chk(!has01(prod1), "R2 serial normalised", 64'(prod1), 64'(0));
        e = (q1.size() > 0) ? q1.pop_front() : '0;
        chk(prod1 == e, "R3 serial product", 64'(prod1), 64'(e));
      end
      pb = busy1; pd = done1;
    end
  end

  // Monitor, digit instance
  initial begin
    int cyc = 0, t0 = 0;
    logic pb = 1'b0, pd = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (busy4 && !pb) t0 = cyc;
      if (pd && done4) chk(1'b0, "R5 digit double done", 64'(done4), 64'(0));
      if (done4) begin
        logic [W-1:0] e;
        nd4++;
        chk(cyc - t0 == N4, "R9 R4 digit latency", 64'(cyc - t0), 64'(N4));
        chk(!has01(prod4), "R2 digit normalised", 64'(prod4), 64'(0));
        e = (q4.size() > 0) ? q4.pop_front() : '0;
        chk(prod4 == e, "R9 R3 digit product", 64'(prod4), 64'(e));
      end
      pb = busy4; pd = done4;
    end
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    nbad++;
    $display("FAIL R4 watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, one, xtop, xone, wrap, zero01, twos;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(prod1 == '0 && prod4 == '0, "R8 reset product", 64'(prod1 | prod4), 64'(0));
    chk(!busy1 && !busy4 && !done1 && !done4, "R8 reset flags",
        64'({busy1, busy4, done1, done4}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    one = '0; one[1:0] = 2'b10;
    issue(one, one, one);                           // R3: 1*1

    xtop = '0; xtop[W-1 -: 2] = 2'b10;              // x^(M-1)
    xone = '0; xone[3:2] = 2'b10;                   // x
    wrap = '0; wrap[1:0] = 2'b10; wrap[2*BK +: 2] = 2'b11;  // 1 - x^K
    issue(xtop, xone, wrap);                        // R3: reduction wrap

    for (int j = 0; j < BM; j++) zero01[2*j +: 2] = 2'b01;
    issue(zero01, enc_rand(1'b0), '0);              // R1: 01 means zero
    issue(enc_rand(1'b0), zero01, '0);              // R1

    for (int j = 0; j < BM; j++) twos[2*j +: 2] = 2'b11;
    issue(twos, twos, ref_mul(twos, twos));         // R3: all twos

    for (int k = 0; k < 16; k++) begin              // R1 R3: mixed zero codes
      a = enc_rand(1'b1); b = enc_rand(1'b1);
      issue(a, b, ref_mul(a, b));
    end

    // R6: start while busy is dropped
    a = enc_rand(1'b0); b = enc_rand(1'b0);
    issue(a, b, ref_mul(a, b));
    @(negedge clk);
    a_in = twos; b_in = twos; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(nd1 == pushes, "R6 serial completions", 64'(nd1), 64'(pushes));
    chk(nd4 == pushes, "R6 digit completions", 64'(nd4), 64'(pushes));

    // R7: product holds while idle
    chk(prod1 == last_exp, "R7 serial hold", 64'(prod1), 64'(last_exp));
    chk(prod4 == last_exp, "R7 digit hold", 64'(prod4), 64'(last_exp));
    chk(!done1 && !done4, "R5 done low when idle", 64'({done1, done4}), 64'(0));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule